// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine for a multicycle processor datapath in which a single ALU, a single unified memory and a register file are reused across the cycles of an instruction. On each clock it reads the opcode and function fields of the instruction word held in the datapath, plus the ALU zero flag. It then drives the select and enable lines that route operands, load the program counter and instruction register, access memory and write the register file.

Four instruction classes are sequenced: register-to-register arithmetic, load word, store word and branch-if-equal. Every instruction spends one cycle in fetch, where memory is read at the PC and the ALU adds four to the PC. It then spends one cycle in decode. Because the ALU is otherwise idle during decode, the sequencer always uses it there to compute the branch target, even when the instruction is not a branch. After decode the path splits by opcode, and each class runs for its own number of cycles before fetch comes round again. The outputs depend only on the state, with two exceptions: the PC load during branch completion follows the zero flag, and the ALU function during arithmetic execution follows the function field.

Top module: `mcc_control`

## Requirements
- R1: Driving `rst_n` low puts the sequencer in fetch at once, whatever state it is in. After release, fetch is presented until the next rising edge.
- R2: In fetch the outputs are pc_load=1, pc_sel=0, addr_sel=0, mem_rd=1, instr_load=1, opa_sel=0, opb_sel=01 and alu_fn=010. All other outputs are 0. The next state is always decode.
- R3: In decode the outputs are opa_sel=0, opb_sel=11 and alu_fn=010, with all else 0. The next state is chosen by opcode: 000000 goes to arithmetic execute, 100011 (load) and 101011 (store) go to address calculation, and 000100 goes to branch completion.
- R4: In address calculation the outputs are opa_sel=1, opb_sel=10 and alu_fn=010, with all else 0 and the zero flag ignored. A load then goes to memory read and a store goes to memory write.
- R5: Memory read drives mem_rd=1 and addr_sel=1 and is followed by load writeback. Load writeback drives rf_we=1, wb_sel=1 and dst_sel=0. In both states all other outputs are 0.
- R6: Memory write drives mem_wr=1 and addr_sel=1, with all else 0. mem_rd and mem_wr are never high together.
- R7: Arithmetic execute drives opa_sel=1 and opb_sel=00, with alu_fn taken from the function field: 100000→010, 100010→110, 100100→000, 100101→001 and 101010→111.
- R8: Arithmetic writeback, which always follows arithmetic execute, drives rf_we=1, dst_sel=1 and wb_sel=0, with all else 0.
- R9: Branch completion drives opa_sel=1, opb_sel=00, alu_fn=110 and pc_sel=1, with pc_load equal to alu_zero_i. It always follows decode, where the target was computed.
- R10: From one fetch to the next, a branch takes 3 cycles, arithmetic and store take 4 each, and a load takes 5.
- R11: In decode, an opcode outside the four listed returns the sequencer to fetch on the next cycle.
- R12: In arithmetic execute, a function code outside the five listed gives alu_fn=010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_i | input | 6 | Opcode field of the held instruction word |
| fn_i | input | 6 | Function field of the held instruction word |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| pc_load_o | output | 1 | Load enable for the program counter |
| pc_sel_o | output | 1 | PC source: 0 ALU result, 1 registered ALU result |
| addr_sel_o | output | 1 | Memory address source: 0 PC, 1 registered ALU result |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| instr_load_o | output | 1 | Instruction register load enable |
| dst_sel_o | output | 1 | Destination register field: 0 rt, 1 rd |
| rf_we_o | output | 1 | Register file write enable |
| wb_sel_o | output | 1 | Write-back source: 0 registered ALU result, 1 memory data register |
| opa_sel_o | output | 1 | ALU operand A: 0 PC, 1 register A |
| opb_sel_o | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_fn_o | output | 3 | ALU operation code |

## Verification
The assertions assume that the opcode input does not change while one instruction is in progress. In the datapath this holds because the opcode comes from an instruction register that is reloaded only in fetch. Under that assumption, properties such as the split after address calculation and a writeback following execute are meaningful. The stimulus table holds the opcode and function fields constant across every row of an instruction and changes them only on fetch rows. The zero flag is left free and is deliberately toggled in states where it must have no effect.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int AF_W = 3;
  localparam int SB_W = 2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MRD, ST_LDWB,
    ST_MWR, ST_REXE, ST_RWB, ST_BRC
  } state_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

  localparam logic [FN_W-1:0] FNC_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FNC_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FNC_AND = 6'b100100;
  localparam logic [FN_W-1:0] FNC_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FNC_SLT = 6'b101010;

  localparam logic [AF_W-1:0] AF_ADD = 3'b010;
  localparam logic [AF_W-1:0] AF_SUB = 3'b110;
  localparam logic [AF_W-1:0] AF_AND = 3'b000;
  localparam logic [AF_W-1:0] AF_OR  = 3'b001;
  localparam logic [AF_W-1:0] AF_SLT = 3'b111;

  localparam logic [SB_W-1:0] OPB_REG   = 2'b00;
  localparam logic [SB_W-1:0] OPB_FOUR  = 2'b01;
  localparam logic [SB_W-1:0] OPB_IMM   = 2'b10;
  localparam logic [SB_W-1:0] OPB_IMMSH = 2'b11;

  typedef struct packed {
    logic            pc_load;
    logic            pc_sel;
    logic            addr_sel;
    logic            mem_rd;
    logic            mem_wr;
    logic            instr_load;
    logic            dst_sel;
    logic            rf_we;
    logic            wb_sel;
    logic            opa_sel;
    logic [SB_W-1:0] opb_sel;
    logic [AF_W-1:0] alu_fn;
  } ctrl_t;
endpackage

// File: rtl/mcc_fndec.sv
module mcc_fndec
  import mcc_pkg::*;
(
  input  logic [FN_W-1:0] fn_i,
  output logic [AF_W-1:0] af_o
);
  always_comb begin
    unique case (fn_i)
      FNC_ADD: af_o = AF_ADD;
      FNC_SUB: af_o = AF_SUB;
      FNC_AND: af_o = AF_AND;
      FNC_OR:  af_o = AF_OR;
      FNC_SLT: af_o = AF_SLT;
      default: af_o = AF_ADD; // R12 fallback
    endcase
  end
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  output state_e          state_o
);
  state_e state_q, state_d;
  logic   op_known;

  assign op_known = (op_i == OPC_RTYPE) || (op_i == OPC_LOAD) ||
                    (op_i == OPC_STORE) || (op_i == OPC_BEQ);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (op_i == OPC_RTYPE)                          state_d = ST_REXE;
        else if (op_i == OPC_LOAD || op_i == OPC_STORE) state_d = ST_ADDR;
        else if (op_i == OPC_BEQ)                       state_d = ST_BRC;
        else                                            state_d = ST_FETCH;
      end
      ST_ADDR: begin
        if (op_i == OPC_LOAD)       state_d = ST_MRD;
        else if (op_i == OPC_STORE) state_d = ST_MWR;
        else                        state_d = ST_FETCH;
      end
      ST_MRD:  state_d = ST_LDWB;
      ST_LDWB: state_d = ST_FETCH;
      ST_MWR:  state_d = ST_FETCH;
      ST_REXE: state_d = ST_RWB;
      ST_RWB:  state_d = ST_FETCH;
      ST_BRC:  state_d = ST_FETCH;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));
  assert_unknown_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && !op_known) |=> (state_q == ST_FETCH));
  assert_mrd_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MRD) |=> (state_q == ST_LDWB));
  assert_branch_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRC) |=> (state_q == ST_FETCH));
endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
  import mcc_pkg::*;
(
  input  state_e          state_i,
  input  logic            zero_i,
  input  logic [AF_W-1:0] rfn_af_i,
  output ctrl_t           ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctl_o.mem_rd     = 1'b1;
        ctl_o.instr_load = 1'b1;
        ctl_o.opb_sel    = OPB_FOUR;
        ctl_o.alu_fn     = AF_ADD;
        ctl_o.pc_load    = 1'b1;
      end
      ST_DECODE: begin
        ctl_o.opb_sel = OPB_IMMSH;
        ctl_o.alu_fn  = AF_ADD;
      end
      ST_ADDR: begin
        ctl_o.opa_sel = 1'b1;
        ctl_o.opb_sel = OPB_IMM;
        ctl_o.alu_fn  = AF_ADD;
      end
      ST_MRD: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl_o.rf_we  = 1'b1;
        ctl_o.wb_sel = 1'b1;
      end
      ST_MWR: begin
        ctl_o.mem_wr   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      ST_REXE: begin
        ctl_o.opa_sel = 1'b1;
        ctl_o.opb_sel = OPB_REG;
        ctl_o.alu_fn  = rfn_af_i;
      end
      ST_RWB: begin
        ctl_o.rf_we   = 1'b1;
        ctl_o.dst_sel = 1'b1;
      end
      ST_BRC: begin
        ctl_o.opa_sel = 1'b1;
        ctl_o.opb_sel = OPB_REG;
        ctl_o.alu_fn  = AF_SUB;
        ctl_o.pc_sel  = 1'b1;
        ctl_o.pc_load = zero_i;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/mcc_control.sv
module mcc_control
  import mcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            alu_zero_i,
  output logic            pc_load_o,
  output logic            pc_sel_o,
  output logic            addr_sel_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            instr_load_o,
  output logic            dst_sel_o,
  output logic            rf_we_o,
  output logic            wb_sel_o,
  output logic            opa_sel_o,
  output logic [SB_W-1:0] opb_sel_o,
  output logic [AF_W-1:0] alu_fn_o
);
  state_e          state;
  logic [AF_W-1:0] rfn_af;
  ctrl_t           ctl;

  mcc_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .state_o (state)
  );

  mcc_fndec u_fndec (
    .fn_i (fn_i),
    .af_o (rfn_af)
  );

  mcc_outdec u_outdec (
    .state_i  (state),
    .zero_i   (alu_zero_i),
    .rfn_af_i (rfn_af),
    .ctl_o    (ctl)
  );

  assign pc_load_o    = ctl.pc_load;
  assign pc_sel_o     = ctl.pc_sel;
  assign addr_sel_o   = ctl.addr_sel;
  assign mem_rd_o     = ctl.mem_rd;
  assign mem_wr_o     = ctl.mem_wr;
  assign instr_load_o = ctl.instr_load;
  assign dst_sel_o    = ctl.dst_sel;
  assign rf_we_o      = ctl.rf_we;
  assign wb_sel_o     = ctl.wb_sel;
  assign opa_sel_o    = ctl.opa_sel;
  assign opb_sel_o    = ctl.opb_sel;
  assign alu_fn_o     = ctl.alu_fn;

  assert_mem_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));
  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_load_o |=> !instr_load_o);
  assert_store_returns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> instr_load_o);
  assert_rwb_after_exe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && dst_sel_o) |-> $past(opa_sel_o && (opb_sel_o == OPB_REG) && !pc_sel_o));
  assert_branch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel_o |-> ($past(opb_sel_o) == OPB_IMMSH));
endmodule

// File: tb/mcc_control_bench.sv
`timescale 1ns/1ps
module mcc_control_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] op;
  logic [5:0] fn;
  logic       z;
  logic pc_load, pc_sel, addr_sel, mem_rd, mem_wr, instr_load;
  logic dst_sel, rf_we, wb_sel, opa_sel;
  logic [1:0] opb_sel;
  logic [2:0] alu_fn;
  logic [14:0] obs;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcc_control u_mcc_control (
    .clk(clk), .rst_n(rst_n), .op_i(op), .fn_i(fn), .alu_zero_i(z),
    .pc_load_o(pc_load), .pc_sel_o(pc_sel), .addr_sel_o(addr_sel),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .instr_load_o(instr_load),
    .dst_sel_o(dst_sel), .rf_we_o(rf_we), .wb_sel_o(wb_sel),
    .opa_sel_o(opa_sel), .opb_sel_o(opb_sel), .alu_fn_o(alu_fn)
  );

  // bit order: pc_load pc_sel addr_sel mem_rd mem_wr instr_load dst_sel rf_we wb_sel opa_sel opb_sel[1:0] alu_fn[2:0]
  assign obs = {pc_load, pc_sel, addr_sel, mem_rd, mem_wr, instr_load,
                dst_sel, rf_we, wb_sel, opa_sel, opb_sel, alu_fn};

  localparam logic [14:0] P_FETCH  = 15'h4A0A;
  localparam logic [14:0] P_DECODE = 15'h001A;
  localparam logic [14:0] P_ADDR   = 15'h0032;
  localparam logic [14:0] P_MRD    = 15'h1800;
  localparam logic [14:0] P_LDWB   = 15'h00C0;
  localparam logic [14:0] P_MWR    = 15'h1400;
  localparam logic [14:0] P_RWB    = 15'h0180;

  // {requirement number, opcode, function, zero, expected outputs}
  localparam int NV = 43;
  localparam logic [31:0] VEC [NV] = '{
    // arithmetic add: R2 R3 R7 R8
    {4'd2, 6'h00, 6'h20, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h20, 1'b0, P_DECODE},
    {4'd7, 6'h00, 6'h20, 1'b0, 15'h0022}, {4'd8, 6'h00, 6'h20, 1'b0, P_RWB},
    // load: R4 (zero ignored) R5
    {4'd2, 6'h23, 6'h00, 1'b0, P_FETCH}, {4'd3, 6'h23, 6'h00, 1'b0, P_DECODE},
    {4'd4, 6'h23, 6'h00, 1'b1, P_ADDR},  {4'd5, 6'h23, 6'h00, 1'b0, P_MRD},
    {4'd5, 6'h23, 6'h00, 1'b0, P_LDWB},
    // store: R4 R6
    {4'd2, 6'h2B, 6'h00, 1'b0, P_FETCH}, {4'd3, 6'h2B, 6'h00, 1'b0, P_DECODE},
    {4'd4, 6'h2B, 6'h00, 1'b0, P_ADDR},  {4'd6, 6'h2B, 6'h00, 1'b0, P_MWR},
    // branch taken and not taken: R9
    {4'd2, 6'h04, 6'h00, 1'b1, P_FETCH}, {4'd3, 6'h04, 6'h00, 1'b1, P_DECODE},
    {4'd9, 6'h04, 6'h00, 1'b1, 15'h6026},
    {4'd2, 6'h04, 6'h00, 1'b0, P_FETCH}, {4'd3, 6'h04, 6'h00, 1'b0, P_DECODE},
    {4'd9, 6'h04, 6'h00, 1'b0, 15'h2026},
    // arithmetic sub, and, or, slt: R7
    {4'd2, 6'h00, 6'h22, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h22, 1'b0, P_DECODE},
    {4'd7, 6'h00, 6'h22, 1'b0, 15'h0026}, {4'd8, 6'h00, 6'h22, 1'b0, P_RWB},
    {4'd2, 6'h00, 6'h24, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h24, 1'b0, P_DECODE},
    {4'd7, 6'h00, 6'h24, 1'b1, 15'h0020}, {4'd8, 6'h00, 6'h24, 1'b0, P_RWB},
    {4'd2, 6'h00, 6'h25, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h25, 1'b0, P_DECODE},
    {4'd7, 6'h00, 6'h25, 1'b0, 15'h0021}, {4'd8, 6'h00, 6'h25, 1'b0, P_RWB},
    {4'd2, 6'h00, 6'h2A, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h2A, 1'b0, P_DECODE},
    {4'd7, 6'h00, 6'h2A, 1'b0, 15'h0027}, {4'd8, 6'h00, 6'h2A, 1'b0, P_RWB},
    // unknown opcode: R11
    {4'd2, 6'h02, 6'h00, 1'b0, P_FETCH}, {4'd11, 6'h02, 6'h00, 1'b0, P_DECODE},
    // unknown function code: R12
    {4'd2, 6'h00, 6'h3F, 1'b0, P_FETCH}, {4'd3, 6'h00, 6'h3F, 1'b0, P_DECODE},
    {4'd12, 6'h00, 6'h3F, 1'b0, 15'h0022}, {4'd8, 6'h00, 6'h3F, 1'b0, P_RWB},
    // unknown opcode again ends in fetch: R11
    {4'd2, 6'h3E, 6'h00, 1'b0, P_FETCH}, {4'd11, 6'h3E, 6'h00, 1'b0, P_DECODE}
  };

  task automatic chk(input logic [14:0] exp, input logic [3:0] rq, input int idx);
    nchk++;
    if (obs !== exp) begin
      nfail++;
      $display("FAIL R%0d step %0d: got %h expected %h", rq, idx, obs, exp);
    end
  endtask

  // R10: cycles from one fetch to the next
  task automatic count_len(input logic [5:0] opc, input int expn, input int idx);
    int n = 0;
    op = opc; fn = 6'h20; z = 1'b0;
    do begin
      n++;
      @(negedge clk); #1;
    end while (obs !== P_FETCH && n < 10);
    nchk++;
    if (n != expn) begin
      nfail++;
      $display("FAIL R10 step %0d: got %0d cycles expected %0d", idx, n, expn);
    end
  endtask

  initial begin
    rst_n = 1'b1; op = '0; fn = '0; z = 1'b0;
    #1 rst_n = 1'b0;
    #1 chk(P_FETCH, 4'd1, 100); // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      op = VEC[i][27:22]; fn = VEC[i][21:16]; z = VEC[i][15];
      #1 chk(VEC[i][14:0], VEC[i][31:28], i);
      @(negedge clk);
    end
    // R10 instruction lengths
    count_len(6'h04, 3, 200);
    count_len(6'h00, 4, 201);
    count_len(6'h2B, 4, 202);
    count_len(6'h23, 5, 203);
    // R1 asynchronous reset in the middle of a load
    op = 6'h23; fn = 6'h00; z = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(P_MRD, 4'd5, 300);
    rst_n = 1'b0;
    #0.5 chk(P_FETCH, 4'd1, 301);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk(P_FETCH, 4'd1, 302);
    @(negedge clk);
    #1 chk(P_DECODE, 4'd1, 303);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule